// File: doc/BRIEF.md
# Read-Out Protection Level Controller

This block holds a 32-bit protection word in a modelled non-volatile cell and turns it into one of four protection levels. Each level sets gating outputs: debug access enable, a debug-lock status flag, a mask of debug mailbox command classes and a mask of in-system programming (ISP) command classes. Each step up in level removes permissions, and no higher level grants a permission that a lower one lacks. Words that are not one of the three protected encodings or the blank value are treated as the sealed level, so a corrupted word fails secure.

Requests come in as single-cycle strobes. A program request writes a new word, but only from the two lowest levels, and the flash rule applies: the write may only clear bits. A mass-erase request restores the blank word, but not from the sealed level, which has no way out. A brick request sets a persistent boot-inhibit flag. After that flag is set, every later request is ignored and all permissions are withdrawn. A request that is refused raises a one-cycle error strobe and leaves the stored word as it was.

The functional reset `rst_n` only re-decodes the level from the stored state. The power-on clear `por_n` models a fresh, erased cell.

Top module: `prot_level_ctrl`

## Requirements
- R1: A stored word of 0xFFFFFFFF reports level code 0 with dbg_en=1, dbg_lock=0, mbox_en=2'b11, isp_en=2'b11.
- R2: A stored word of 0x00000003 reports level code 1 with dbg_en=0, dbg_lock=0, mbox_en=2'b01, isp_en=2'b01.
- R3: A stored word of 0x00000001 reports level code 2 with dbg_en=0, dbg_lock=1, mbox_en=2'b01, isp_en=2'b01.
- R4: A stored word of 0x00000000, or any word not named in R1 to R3, reports level code 3 with dbg_en=0, dbg_lock=1, mbox_en=2'b00, isp_en=2'b00.
- R5: A program request is accepted at level 0 for any word. At level 1 it is accepted only when the new word sets no bit that is currently clear. At level 2 or 3 it is always refused.
- R6: An erase request at level 0, 1 or 2 sets the stored word to 0xFFFFFFFF. At level 3 it is refused.
- R7: While the level is 3, the stored word never changes until a power-on clear.
- R8: A brick request is accepted at any level. boot_inhibit rises at the next edge, and one edge later all permissions read as in R4. Every later request is ignored without an error. The flag survives rst_n.
- R9: A refused request raises req_err for exactly one cycle, at the edge that samples the request, and leaves prot_word unchanged.
- R10: prot_word, boot_inhibit and req_err update at the edge that samples a request. level and the permission outputs follow one edge later.
- R11: While rst_n is low, level reads 3, all permissions are off and req_err is 0. The stored word and brick flag are kept, and the first edge after release re-decodes from them.
- R12: While por_n is low, prot_word resets to 0xFFFFFFFF and boot_inhibit to 0.
- R13: When requests coincide, brick takes priority over erase, and erase over program. The lower-priority requests are dropped without an error.
- R14: For each mask, a set class bit i>0 implies bit i-1 is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Functional reset, active low, asynchronous assert |
| por_n | input | 1 | Power-on clear of the modelled cell, active low |
| prog_req | input | 1 | Program strobe |
| prog_word | input | 32 | Word to program |
| erase_req | input | 1 | Mass-erase strobe |
| brick_req | input | 1 | Permanent boot-disable strobe |
| level | output | 2 | Current protection level code |
| dbg_en | output | 1 | Debug access allowed |
| dbg_lock | output | 1 | Debug configuration locked |
| mbox_en | output | MBOX_W | Debug mailbox command-class enables |
| isp_en | output | ISP_W | ISP command-class enables |
| boot_inhibit | output | 1 | Boot disabled permanently |
| req_err | output | 1 | One-cycle refusal strobe |
| prot_word | output | 32 | Stored protection word |

## Verification
The in-line assertions check the following on every cycle:
- the sealed level freezes the word;
- writes other than erase only clear bits;
- the brick flag is sticky and withdraws permissions;
- a refusal never coincides with a change of the word;
- the class masks stay nested.

Only the bench's scenarios can show the rest:
- the exact decode of each encoding, including fallback words;
- which requests are accepted at which level;
- the one-edge lag between the stored word and the permission outputs;
- priority among coincident strobes;
- that rst_n keeps the stored state while por_n clears it.

// File: rtl/prot_level_pkg.sv
package prot_level_pkg;

  localparam int unsigned WORD_W = 32;

  typedef logic [WORD_W-1:0] pword_t;

  // Word encodings the decoder recognises; everything else falls back to sealed.
  localparam pword_t WORD_BLANK  = {WORD_W{1'b1}};
  localparam pword_t WORD_SOFT   = pword_t'(3);
  localparam pword_t WORD_LOCKED = pword_t'(1);
  localparam pword_t WORD_SEALED = pword_t'(0);

  typedef enum logic [1:0] {
    LVL_OPEN   = 2'd0,
    LVL_SOFT   = 2'd1,
    LVL_LOCKED = 2'd2,
    LVL_SEALED = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_PROG  = 2'd1,
    ACT_ERASE = 2'd2,
    ACT_BRICK = 2'd3
  } act_e;

  function automatic lvl_e decode_word(pword_t w);
    lvl_e l;
    case (w)
      WORD_BLANK:  l = LVL_OPEN;
      WORD_SOFT:   l = LVL_SOFT;
      WORD_LOCKED: l = LVL_LOCKED;
      default:     l = LVL_SEALED;
    endcase
    return l;
  endfunction

  // Highest level at which command class idx stays enabled.
  function automatic lvl_e class_ceiling(int unsigned idx);
    return (idx == 0) ? LVL_LOCKED : LVL_OPEN;
  endfunction

endpackage

// File: rtl/prot_nv_cell.sv
module prot_nv_cell
  import prot_level_pkg::*;
(
  input  logic   clk,
  input  logic   por_n,
  input  logic   wr_en,
  input  pword_t wr_data,
  input  logic   brick_set,
  output pword_t word_q,
  output logic   brick_q
);

  pword_t word_d;
  logic   brick_d;

  always_comb begin
    word_d  = word_q;
    brick_d = brick_q;
    if (wr_en)     word_d  = wr_data;
    if (brick_set) brick_d = 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      word_q  <= WORD_BLANK;
      brick_q <= 1'b0;
    end else begin
      if (wr_en)     word_q  <= word_d;
      if (brick_set) brick_q <= brick_d;
    end
  end

  a_r8_brick_sticky: assert property (@(posedge clk) disable iff (!por_n)
    brick_q |=> brick_q);

  a_r7_sealed_frozen: assert property (@(posedge clk) disable iff (!por_n)
    (decode_word(word_q) == LVL_SEALED) |=> $stable(word_q));

  a_r5_clear_only: assert property (@(posedge clk) disable iff (!por_n)
    ((word_q != $past(word_q)) && (word_q != WORD_BLANK))
      |-> ((word_q & ~$past(word_q)) == '0));

endmodule

// File: rtl/prot_req_arbiter.sv
module prot_req_arbiter
  import prot_level_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   prog_req,
  input  pword_t prog_word,
  input  logic   erase_req,
  input  logic   brick_req,
  input  pword_t word_q,
  input  logic   brick_q,
  output logic   wr_en,
  output pword_t wr_data,
  output logic   brick_set,
  output logic   err_q
);

  lvl_e cur_lvl;
  act_e act;
  logic clear_only;
  logic err_d;

  always_comb begin
    cur_lvl    = decode_word(word_q);
    clear_only = ((prog_word & ~word_q) == '0);
    if (brick_req)      act = ACT_BRICK;
    else if (erase_req) act = ACT_ERASE;
    else if (prog_req)  act = ACT_PROG;
    else                act = ACT_NONE;
  end

  always_comb begin
    wr_en     = 1'b0;
    wr_data   = word_q;
    brick_set = 1'b0;
    err_d     = 1'b0;
    if (rst_n && !brick_q) begin
      unique case (act)
        ACT_BRICK: brick_set = 1'b1;
        ACT_ERASE: begin
          if (cur_lvl != LVL_SEALED) begin
            wr_en   = 1'b1;
            wr_data = WORD_BLANK;
          end else begin
            err_d = 1'b1;
          end
        end
        ACT_PROG: begin
          if (((cur_lvl == LVL_OPEN) || (cur_lvl == LVL_SOFT)) && clear_only) begin
            wr_en   = 1'b1;
            wr_data = prog_word;
          end else begin
            err_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  a_r13_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && brick_set));

  a_r5_locked_no_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl == LVL_LOCKED) |-> !(wr_en && (wr_data != WORD_BLANK)));

  a_r8_bricked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    brick_q |=> !err_q);

endmodule

// File: rtl/prot_perm_gate.sv
module prot_perm_gate
  import prot_level_pkg::*;
#(
  parameter int unsigned MBOX_W = 2,
  parameter int unsigned ISP_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pword_t            word_q,
  input  logic              brick_q,
  output lvl_e              level_q,
  output logic              dbg_en_q,
  output logic              dbg_lock_q,
  output logic [MBOX_W-1:0] mbox_q,
  output logic [ISP_W-1:0]  isp_q
);

  lvl_e              lvl_d;
  logic              dbg_en_d;
  logic              dbg_lock_d;
  logic [MBOX_W-1:0] mbox_d;
  logic [ISP_W-1:0]  isp_d;

  always_comb begin
    lvl_d      = decode_word(word_q);
    dbg_en_d   = (lvl_d == LVL_OPEN) && !brick_q;
    dbg_lock_d = brick_q || (lvl_d == LVL_LOCKED) || (lvl_d == LVL_SEALED);
  end

  for (genvar gi = 0; gi < MBOX_W; gi++) begin : g_mbox
    localparam lvl_e CEIL = class_ceiling(gi);
    assign mbox_d[gi] = !brick_q && (lvl_d <= CEIL);
    if (gi > 0) begin : g_nest
      a_r14_mbox_nested: assert property (@(posedge clk) disable iff (!rst_n)
        mbox_q[gi] |-> mbox_q[gi-1]);
    end
  end

  for (genvar gi = 0; gi < ISP_W; gi++) begin : g_isp
    localparam lvl_e CEIL = class_ceiling(gi);
    assign isp_d[gi] = !brick_q && (lvl_d <= CEIL);
    if (gi > 0) begin : g_nest
      a_r14_isp_nested: assert property (@(posedge clk) disable iff (!rst_n)
        isp_q[gi] |-> isp_q[gi-1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q    <= LVL_SEALED;
      dbg_en_q   <= 1'b0;
      dbg_lock_q <= 1'b1;
      mbox_q     <= '0;
      isp_q      <= '0;
    end else begin
      level_q    <= lvl_d;
      dbg_en_q   <= dbg_en_d;
      dbg_lock_q <= dbg_lock_d;
      mbox_q     <= mbox_d;
      isp_q      <= isp_d;
    end
  end

  a_r4_sealed_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q == LVL_SEALED) |-> (mbox_q == '0 && isp_q == '0 && !dbg_en_q && dbg_lock_q));

  a_r8_brick_withdraws: assert property (@(posedge clk) disable iff (!rst_n)
    brick_q |=> (!dbg_en_q && mbox_q == '0 && isp_q == '0));

  a_r1_open_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_en_q |-> !dbg_lock_q);

endmodule

// File: rtl/prot_level_ctrl.sv
module prot_level_ctrl
  import prot_level_pkg::*;
#(
  parameter int unsigned MBOX_W = 2,
  parameter int unsigned ISP_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              prog_req,
  input  logic [31:0]       prog_word,
  input  logic              erase_req,
  input  logic              brick_req,
  output logic [1:0]        level,
  output logic              dbg_en,
  output logic              dbg_lock,
  output logic [MBOX_W-1:0] mbox_en,
  output logic [ISP_W-1:0]  isp_en,
  output logic              boot_inhibit,
  output logic              req_err,
  output logic [31:0]       prot_word
);

  pword_t word_q;
  pword_t wr_data;
  logic   brick_q;
  logic   wr_en;
  logic   brick_set;
  lvl_e   level_q;

  prot_nv_cell u_cell (
    .clk       (clk),
    .por_n     (por_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .brick_set (brick_set),
    .word_q    (word_q),
    .brick_q   (brick_q)
  );

  prot_req_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_req  (prog_req),
    .prog_word (prog_word),
    .erase_req (erase_req),
    .brick_req (brick_req),
    .word_q    (word_q),
    .brick_q   (brick_q),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .brick_set (brick_set),
    .err_q     (req_err)
  );

  prot_perm_gate #(
    .MBOX_W (MBOX_W),
    .ISP_W  (ISP_W)
  ) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_q     (word_q),
    .brick_q    (brick_q),
    .level_q    (level_q),
    .dbg_en_q   (dbg_en),
    .dbg_lock_q (dbg_lock),
    .mbox_q     (mbox_en),
    .isp_q      (isp_en)
  );

  assign level        = level_q;
  assign boot_inhibit = brick_q;
  assign prot_word    = word_q;

  a_r9_reject_keeps_word: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    req_err |-> $stable(prot_word));

endmodule

// File: tb/prot_level_ctrl_tb_top.sv
module prot_level_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic        por_n;
  logic        prog_req;
  logic [31:0] prog_word;
  logic        erase_req;
  logic        brick_req;
  logic [1:0]  level;
  logic        dbg_en;
  logic        dbg_lock;
  logic [1:0]  mbox_en;
  logic [1:0]  isp_en;
  logic        boot_inhibit;
  logic        req_err;
  logic [31:0] prot_word;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  prot_level_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .prog_req(prog_req), .prog_word(prog_word),
    .erase_req(erase_req), .brick_req(brick_req),
    .level(level), .dbg_en(dbg_en), .dbg_lock(dbg_lock),
    .mbox_en(mbox_en), .isp_en(isp_en),
    .boot_inhibit(boot_inhibit), .req_err(req_err), .prot_word(prot_word)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // op bits: [2] brick, [1] erase, [0] program
  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] wd;
    logic        err;
    logic [31:0] word;
    logic [1:0]  lvl;
    logic        boot;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [0:NV-1] = '{
    '{3'b010, 32'h0,         1'b0, 32'hFFFF_FFFF, 2'd0, 1'b0}, // R6 erase at open, R1
    '{3'b001, 32'h3,         1'b0, 32'h3,         2'd1, 1'b0}, // R5 R2
    '{3'b001, 32'hFFFF_FFFF, 1'b1, 32'h3,         2'd1, 1'b0}, // R5 R9 sets bits
    '{3'b001, 32'h1,         1'b0, 32'h1,         2'd2, 1'b0}, // R5 R3 clear at soft
    '{3'b001, 32'h0,         1'b1, 32'h1,         2'd2, 1'b0}, // R5 R9 locked
    '{3'b010, 32'h0,         1'b0, 32'hFFFF_FFFF, 2'd0, 1'b0}, // R6 erase from locked
    '{3'b001, 32'h1,         1'b0, 32'h1,         2'd2, 1'b0}, // R5 open to locked
    '{3'b010, 32'h0,         1'b0, 32'hFFFF_FFFF, 2'd0, 1'b0}, // R6
    '{3'b011, 32'h0,         1'b0, 32'hFFFF_FFFF, 2'd0, 1'b0}, // R13 erase beats program
    '{3'b001, 32'h3,         1'b0, 32'h3,         2'd1, 1'b0}, // R2
    '{3'b001, 32'h2,         1'b0, 32'h2,         2'd3, 1'b0}, // R4 fallback word
    '{3'b010, 32'h0,         1'b1, 32'h2,         2'd3, 1'b0}, // R6 R7 erase refused
    '{3'b001, 32'h0,         1'b1, 32'h2,         2'd3, 1'b0}, // R7 program refused
    '{3'b110, 32'h0,         1'b0, 32'h2,         2'd3, 1'b1}, // R13 R8 brick beats erase
    '{3'b010, 32'h0,         1'b0, 32'h2,         2'd3, 1'b1}, // R8 ignored silently
    '{3'b001, 32'h0,         1'b0, 32'h2,         2'd3, 1'b1}  // R8 ignored silently
  };

  function automatic logic [5:0] exp_perm(logic [1:0] l, logic b);
    if (b) return 6'b01_00_00;
    case (l)
      2'd0:    return 6'b10_11_11;
      2'd1:    return 6'b00_01_01;
      2'd2:    return 6'b01_01_01;
      default: return 6'b01_00_00;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(string req, logic [1:0] l, logic b);
    chk({req, " level"}, {30'b0, level}, {30'b0, l});
    chk({req, " perms"}, {26'b0, dbg_en, dbg_lock, mbox_en, isp_en}, {26'b0, exp_perm(l, b)});
  endtask

  // Called at a negedge; returns at a negedge two edges later.
  task automatic apply(logic [2:0] op, logic [31:0] wd, string req,
                       logic e_err, logic [31:0] e_word, logic [1:0] e_lvl, logic e_boot);
    brick_req = op[2]; erase_req = op[1]; prog_req = op[0]; prog_word = wd;
    @(posedge clk);
    @(negedge clk);
    brick_req = 1'b0; erase_req = 1'b0; prog_req = 1'b0;
    chk({req, " R9 err"}, {31'b0, req_err}, {31'b0, e_err});
    chk({req, " R10 word"}, prot_word, e_word);
    chk({req, " R8 boot"}, {31'b0, boot_inhibit}, {31'b0, e_boot});
    @(posedge clk);
    @(negedge clk);
    chk({req, " R9 err pulse ended"}, {31'b0, req_err}, 32'h0);
    chk_state(req, e_lvl, e_boot);
  endtask

  task automatic pulse_reset(bit with_por);
    @(negedge clk);
    rst_n = 1'b0;
    if (with_por) por_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R11 in reset", {31'b0, req_err}, 32'h0);
    chk_state("R11 in reset", 2'd3, 1'b1);
    rst_n = 1'b1;
    por_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; por_n = 1'b0;
    prog_req = 1'b0; erase_req = 1'b0; brick_req = 1'b0; prog_word = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R12 por word", prot_word, 32'hFFFF_FFFF);
    chk("R12 por boot", {31'b0, boot_inhibit}, 32'h0);
    chk_state("R11 in reset", 2'd3, 1'b1);
    rst_n = 1'b1; por_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk_state("R1 R11 after release", 2'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].wd, $sformatf("vec%0d", i),
            VECS[i].err, VECS[i].word, VECS[i].lvl, VECS[i].boot);
    end

    // R8 R11: functional reset keeps the brick flag and word
    pulse_reset(1'b0);
    chk("R8 boot after rst", {31'b0, boot_inhibit}, 32'h1);
    chk("R11 word after rst", prot_word, 32'h2);
    chk_state("R8 after rst", 2'd3, 1'b1);

    // R12: power-on clears; R4 R7 exact sealed word
    pulse_reset(1'b1);
    chk("R12 word", prot_word, 32'hFFFF_FFFF);
    chk("R12 boot", {31'b0, boot_inhibit}, 32'h0);
    chk_state("R1 after por", 2'd0, 1'b0);
    apply(3'b001, 32'h0, "R4 seal", 1'b0, 32'h0, 2'd3, 1'b0);
    apply(3'b010, 32'h0, "R7 erase sealed", 1'b1, 32'h0, 2'd3, 1'b0);
    pulse_reset(1'b0);
    chk_state("R11 sealed kept", 2'd3, 1'b0);

    // R11: locked level re-decoded after functional reset
    pulse_reset(1'b1);
    apply(3'b001, 32'h1, "R3 lock", 1'b0, 32'h1, 2'd2, 1'b0);
    pulse_reset(1'b0);
    chk_state("R11 locked kept", 2'd2, 1'b0);

    // R10: word moves at the sampling edge, level one edge later
    pulse_reset(1'b1);
    prog_req = 1'b1; prog_word = 32'h3;
    @(posedge clk);
    @(negedge clk);
    prog_req = 1'b0;
    chk("R10 word first edge", prot_word, 32'h3);
    chk_state("R10 level lags", 2'd0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk_state("R10 level second edge", 2'd1, 1'b0);

    // R8: brick at open level withdraws everything
    pulse_reset(1'b1);
    apply(3'b100, 32'h0, "R8 brick open", 1'b0, 32'hFFFF_FFFF, 2'd0, 1'b1);
    apply(3'b001, 32'h3, "R8 prog ignored", 1'b0, 32'hFFFF_FFFF, 2'd0, 1'b1);

    finished = 1;
    summary();
    $finish;
  end

endmodule